// File: doc/BRIEF.md
# SIMT Divergence Predicate Mask Unit

This unit tracks which lanes of a 64-lane wavefront may write results while the wavefront runs through an if/else construct. When a branch is presented, the unit splits the current active mask into a taken set (lanes whose condition bit is 1) and a fall-through set (lanes whose condition bit is 0). It issues the taken path under the taken set, then the else path under the fall-through set. When both paths are done it restores the mask that was in force before the branch.

Each path is modelled by an instruction count given with the branch. The unit issues one instruction per clock and drives a lane write-enable vector with it. A path whose lane set is empty, or whose count is zero, is dropped when the branch is accepted, so it costs no issue cycles. If the whole wavefront agrees on the condition, only one path is ever issued. A four-deep frame stack lets a branch arrive while a path is running. The interrupted path resumes when the inner branch reconverges.

Top module: `simt_branch_mask`

## Requirements
- R1: After reset, active_mask is all ones, depth is 0, issue_valid is 0, lane_we is all zeros and overflow is 0.
- R2: On a divergent branch, the unit issues one instruction per cycle. It first issues br_then_len cycles with lane_we = pre & cond and in_else = 0. It then issues br_else_len cycles with lane_we = pre & ~cond and in_else = 1. Here pre is the active_mask at the branch.
- R3: If pre & ~cond is zero, no else cycles are issued. If pre & cond is zero, no taken cycles are issued and issue starts directly with in_else = 1.
- R4: A path with a zero count is skipped in the same way as a path with an empty lane set. If both paths are skipped, the branch changes nothing: depth, active_mask and issue_valid stay as they were.
- R5: In the cycle after the last instruction of a branch issues, active_mask equals that branch's pre mask again and depth is one lower.
- R6: A branch accepted while a path is issuing uses that path's mask as its pre mask. After it reconverges, the interrupted path issues its remaining instructions under its own mask and phase.
- R7: A branch presented while depth equals 4 is ignored. Depth never exceeds 4, and overflow becomes 1 and stays 1 until reset.
- R8: In a cycle with br_valid high, issue_valid is 0 and no instruction is consumed.
- R9: When depth is 0, issue_valid is 0 and lane_we is all zeros.
- R10: The number of issue cycles for one branch equals the sum of the counts of its non-skipped paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_cond | input | 64 | Per-lane branch condition, 1 selects the taken path |
| br_then_len | input | 8 | Instruction count of the taken path |
| br_else_len | input | 8 | Instruction count of the else path |
| issue_valid | output | 1 | An instruction issues this cycle |
| lane_we | output | 64 | Lane write enables for the issued instruction |
| in_else | output | 1 | 1 while the else path of the innermost branch issues |
| active_mask | output | 64 | Mask currently in force |
| depth | output | 3 | Number of open branch frames |
| overflow | output | 1 | Sticky flag: a branch was dropped at full depth |

## Verification
Condition vectors are swept with every combination of path counts from 0 to 3. The vectors are all ones and all zeros, which separate the uniform cases from real divergence. Even/odd lanes and a lower/upper half split check that complementary masks leave no lane out. An irregular vector catches lane-order mistakes. The same sweep runs a second time inside an enclosing branch, so the AND with the pre mask can be told apart from the raw condition. A hand-timed nested branch inside a taken path shows whether the parent resumes correctly. Five stacked branches test the overflow drop.

// File: rtl/simt_branch_mask.sv
module simt_branch_mask #(
  parameter int LANES = 64,
  parameter int DEPTH = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic [LEN_W-1:0] br_then_len,
  input  logic [LEN_W-1:0] br_else_len,
  output logic             issue_valid,
  output logic [LANES-1:0] lane_we,
  output logic             in_else,
  output logic [LANES-1:0] active_mask,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic             overflow
);
  localparam int SPW = $clog2(DEPTH+1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] ret_q [DEPTH];
  logic [LANES-1:0] alt_q [DEPTH];
  logic [LEN_W-1:0] alt_n [DEPTH];
  logic [LEN_W-1:0] rem_q [DEPTH];
  logic             ph_q  [DEPTH];

  logic [SPW-1:0]   sp;
  logic [LANES-1:0] cur;
  logic             ovf;

  logic [IW-1:0]    top, nxt;
  logic [LANES-1:0] t_m, e_m;
  logic [LEN_W-1:0] tl, el;
  logic             open, full, last;

  assign top  = IW'(sp - 1'b1);
  assign nxt  = IW'(sp);
  assign open = (sp != '0);
  assign full = (sp == SPW'(DEPTH));
  assign t_m  = cur & br_cond;
  assign e_m  = cur & ~br_cond;
  assign tl   = (|t_m) ? br_then_len : '0;
  assign el   = (|e_m) ? br_else_len : '0;
  assign last = (rem_q[top] == LEN_W'(1));

  assign issue_valid = open & ~br_valid;
  assign lane_we     = issue_valid ? cur : '0;
  assign in_else     = open & ph_q[top];
  assign active_mask = cur;
  assign depth       = sp;
  assign overflow    = ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= '0;
      cur <= '1;
      ovf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        ret_q[i] <= '0;
        alt_q[i] <= '0;
        alt_n[i] <= '0;
        rem_q[i] <= '0;
        ph_q[i]  <= 1'b0;
      end
    end else if (br_valid) begin
      if (full) begin
        ovf <= 1'b1;
      end else if (tl != '0 || el != '0) begin
        ret_q[nxt] <= cur;
        alt_q[nxt] <= e_m;
        alt_n[nxt] <= el;
        sp         <= sp + 1'b1;
        if (tl != '0) begin
          ph_q[nxt]  <= 1'b0;
          rem_q[nxt] <= tl;
          cur        <= t_m;
        end else begin
          ph_q[nxt]  <= 1'b1;
          rem_q[nxt] <= el;
          cur        <= e_m;
        end
      end
    end else if (open) begin
      if (!last) begin
        rem_q[top] <= rem_q[top] - 1'b1;
      end else if (!ph_q[top] && alt_n[top] != '0) begin
        ph_q[top]  <= 1'b1;
        rem_q[top] <= alt_n[top];
        cur        <= alt_q[top];
      end else begin
        cur <= ret_q[top];
        sp  <= sp - 1'b1;
      end
    end
  end
endmodule

// File: rtl/simt_branch_mask_chk.sv
module simt_branch_mask_chk #(
  parameter int LANES = 64,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic             issue_valid,
  input logic [LANES-1:0] lane_we,
  input logic             in_else,
  input logic [LANES-1:0] active_mask,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic             overflow
);
  localparam int SPW = $clog2(DEPTH+1);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SPW'(DEPTH));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(br_valid) && $past(depth) == SPW'(DEPTH)));

  // R8
  br_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> !issue_valid);

  // R5
  pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth < $past(depth)) |->
      ((($past(active_mask) & ~active_mask) == '0) && depth == $past(depth) - 1'b1));

  // R2
  else_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_else) && depth == $past(depth)) |-> (($past(active_mask) & active_mask) == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (!issue_valid && lane_we == '0));
endmodule

bind simt_branch_mask simt_branch_mask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .issue_valid(issue_valid),
  .lane_we(lane_we), .in_else(in_else), .active_mask(active_mask),
  .depth(depth), .overflow(overflow)
);

// File: tb/sim_simt_branch_mask.sv
`timescale 1ns/1ps
module sim_simt_branch_mask;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        br_valid = 0;
  logic [63:0] br_cond = '0;
  logic [7:0]  br_then_len = '0, br_else_len = '0;
  logic        issue_valid, in_else, overflow;
  logic [63:0] lane_we, active_mask;
  logic [2:0]  depth;

  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [63:0] EVEN = 64'h5555_5555_5555_5555;
  localparam logic [63:0] ODD  = 64'hAAAA_AAAA_AAAA_AAAA;
  localparam logic [63:0] LOWH = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] OUTER = 64'hF0F0_3C3C_FF00_0FF0;

  simt_branch_mask u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
    .br_then_len(br_then_len), .br_else_len(br_else_len),
    .issue_valid(issue_valid), .lane_we(lane_we), .in_else(in_else),
    .active_mask(active_mask), .depth(depth), .overflow(overflow)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int p);
    case (p)
      0: pat = '1;
      1: pat = '0;
      2: pat = EVEN;
      3: pat = LOWH;
      default: pat = 64'h9E37_79B9_7F4A_7C15;
    endcase
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_branch(input logic [63:0] cond, input int tl, input int el,
                            input logic [63:0] pre, input int d0);
    logic [63:0] t, e;
    int te, ee, n;
    t = pre & cond;
    e = pre & ~cond;
    te = (t != 0) ? tl : 0;
    ee = (e != 0) ? el : 0;
    @(negedge clk);
    br_valid = 1; br_cond = cond; br_then_len = 8'(tl); br_else_len = 8'(el);
    #1;
    chk(issue_valid == 0, "R8", 64'(issue_valid), 64'd0);
    @(negedge clk);
    br_valid = 0;
    #1;
    n = 0;
    for (int k = 0; k < te + ee; k++) begin
      if (k < te)
        chk(issue_valid && lane_we == t && !in_else && depth == 3'(d0 + 1), "R2", lane_we, t);
      else
        chk(issue_valid && lane_we == e && in_else && depth == 3'(d0 + 1),
            (te == 0) ? "R3" : "R2", lane_we, e);
      n++;
      step();
    end
    chk(n == te + ee, "R10", 64'(n), 64'(te + ee));
    chk(depth == 3'(d0) && active_mask == pre, (te + ee == 0) ? "R4" : "R5", active_mask, pre);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(active_mask == '1 && depth == 0 && !issue_valid && lane_we == 0 && !overflow,
        "R1", active_mask, '1);

    // top-level sweep: R2 R3 R4 R5 R10
    for (int p = 0; p < 5; p++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          run_branch(pat(p), a, b, '1, 0);

    // sweep inside an enclosing branch: R6 pre mask is the path mask
    @(negedge clk);
    br_valid = 1; br_cond = OUTER; br_then_len = 8'd250; br_else_len = 8'd0;
    @(negedge clk);
    br_valid = 0;
    #1;
    chk(depth == 1 && active_mask == OUTER && lane_we == OUTER, "R6", active_mask, OUTER);
    for (int p = 0; p < 5; p++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          run_branch(pat(p), a, b, OUTER, 1);
    n = 0;
    while (depth != 0 && n < 400) begin step(); n++; end
    chk(depth == 0 && active_mask == '1, "R5", active_mask, '1);
    chk(!issue_valid && lane_we == 0, "R9", lane_we, 64'd0);

    // explicit nested case: R6
    @(negedge clk);
    br_valid = 1; br_cond = EVEN; br_then_len = 8'd2; br_else_len = 8'd2;
    @(negedge clk);
    br_valid = 0;
    #1;
    chk(issue_valid && lane_we == EVEN && !in_else && depth == 1, "R2", lane_we, EVEN);
    @(negedge clk);
    br_valid = 1; br_cond = LOWH; br_then_len = 8'd1; br_else_len = 8'd1;
    #1;
    chk(!issue_valid, "R8", 64'(issue_valid), 64'd0);
    @(negedge clk);
    br_valid = 0;
    #1;
    chk(depth == 2 && lane_we == (EVEN & LOWH) && !in_else, "R6", lane_we, EVEN & LOWH);
    step();
    chk(depth == 2 && lane_we == (EVEN & ~LOWH) && in_else, "R6", lane_we, EVEN & ~LOWH);
    step();
    chk(depth == 1 && lane_we == EVEN && !in_else, "R6", lane_we, EVEN);
    step();
    chk(depth == 1 && lane_we == ODD && in_else, "R6", lane_we, ODD);
    step();
    chk(depth == 1 && lane_we == ODD && in_else, "R6", lane_we, ODD);
    step();
    chk(depth == 0 && active_mask == '1, "R5", active_mask, '1);

    // overflow: R7
    @(negedge clk);
    br_valid = 1; br_cond = '1; br_then_len = 8'd5; br_else_len = 8'd0;
    repeat (5) @(negedge clk);
    br_valid = 0;
    #1;
    chk(depth == 4 && overflow, "R7", {61'd0, depth}, 64'd4);
    n = 0;
    while (depth != 0 && n < 100) begin
      if (issue_valid) n++;
      step();
    end
    chk(n == 20, "R7", 64'(n), 64'd20);
    chk(overflow, "R7", 64'(overflow), 64'd1);

    // reset clears the sticky flag: R1
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!overflow && depth == 0 && active_mask == '1, "R1", 64'(overflow), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule